// File: doc/BRIEF.md
# Watchdog Reset Generator with Reset-Cause Flag

This block watches software through an 8-bit timeout counter and, when software fails to service it or writes a malformed control word, drives the chip's open-drain reset pin low for a fixed pulse. The flag that tells a watchdog reset apart from any other reset is not latched when the pulse is issued. After the pulse ends, the block waits a long delay counted in system-clock ticks and only then samples the synchronised pin. If the pin is high at that point, the flag is set. If the pin is still low, which means something outside is holding it, the flag stays clear. Whenever the pin is seen low, the flag is cleared.

Everything runs from one input clock. The system-clock rate is modelled as a tick enable whose divide ratio comes from a 2-bit divider select. Ratios are 4 for select 0, 2 for selects 1 and 2, and 1 for select 3. The delay is therefore fixed in ticks but varies in real time. A slow board RC on the pin can hide the flag if the pin is still low when the sample is taken.

The reset-cause controller is a four-state machine:
- `ST_IDLE` goes to `ST_PULSE` on a trigger (T_TRIG).
- `ST_PULSE` goes to `ST_DELAY` once the pulse count is complete (T_RELEASE).
- `ST_DELAY` goes to `ST_SAMPLE` when the last delay tick arrives (T_EXPIRE). It goes back to `ST_PULSE` if a new trigger arrives first (T_RETRIG).
- `ST_SAMPLE` goes to `ST_IDLE` after one cycle (T_DONE).

Top module: `wd_reset_cause`

## Requirements
- R1: With the enable bit set, the counter advances once every WD_PRESCALE clocks. When it passes its all-ones value it raises a trigger, and the pull-down output rises exactly 256*WD_PRESCALE+1 clock edges after the edge that captured the enabling write.
- R2: A key-port write of 0xAA clears the counter and prescaler only if the previous key write was 0x55. Any other key write in between cancels the arming, and the following 0xAA then has no effect.
- R3: A control write whose bits [5:0] differ from 6'b101000 triggers a reset regardless of the enable bit. The pull-down output rises on the second clock edge counting the capturing edge as the first.
- R4: The pull-down output stays high for exactly RST_PULSE consecutive clocks.
- R5: The pin input passes through a two-flop synchroniser. A low pin clears the flag, and the flag reads 0 after the third clock edge once the pin goes low.
- R6: Take the first cycle with the pull-down low as cycle 1. The sample is taken SAMPLE_DELAY system ticks after the pulse ends (ratio 4/2/2/1 for select 0/1/2/3). A high synchronised pin there makes the flag first read 1 in cycle SAMPLE_DELAY*ratio+2.
- R7: If the synchronised pin is low at the sample point, the flag stays 0, including after the pin is later released. A low pin with no watchdog trigger never sets the flag.
- R8: A valid control write with bit 7 = 1 clears the flag. A valid write with bit 7 = 0 leaves the flag unchanged.
- R9: The read port returns the flag in bit 7, the enable in bit 6, and zeros in bits [5:0]. A valid write loads the enable from bit 6.
- R10: While the synchronised pin is low, the enable, counter, prescaler and key arming are held cleared, so control writes are ignored.
- R11: While por_n is low, the flag, the enable and the pull-down output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock for the counter and the controller |
| por_n | input | 1 | Active-low power-on reset |
| sys_div_sel | input | 2 | System-clock divider select for the sample delay |
| rst_pin_i | input | 1 | Level seen on the external reset pin |
| rst_pin_pd_o | output | 1 | Pull-down enable for the open-drain reset pin |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: flag-clear, enable, check field |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 8 | Key write data |
| ctrl_rdata | output | 8 | Control register read value |

## Verification
On every cycle, the assertions check the following:
- the pulse length;
- that the flag clears when the pin is low;
- that the flag rises only out of the sample state, with the pin high;
- that a low pin at the sample point keeps the flag at 0;
- that the enable stays clear while the pin is low;
- the effect of a bad check write and of the key sequence;
- that an overflow starts only from the all-ones count.

Only the bench scenarios can show the absolute latencies: the expiry time, the sample time under each divider ratio, and a board RC that finishes just before the sample compared with one that finishes just after it. The bench also confirms that the flag remains clear once a late pin is released.

// File: rtl/wd_reset_pkg.sv
package wd_reset_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_DELAY,
        ST_SAMPLE
    } cause_state_e;

    // Low six control bits a legal write must carry
    localparam logic [5:0] CTRL_CHECK = 6'b101000;
    localparam logic [7:0] KEY_ARM    = 8'h55;
    localparam logic [7:0] KEY_FIRE   = 8'hAA;

    // Last value of the tick divider for a divider select
    function automatic logic [1:0] div_last(input logic [1:0] sel);
        case (sel)
            2'd3:    div_last = 2'd0;
            2'd0:    div_last = 2'd3;
            default: div_last = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/wd_sync2.sv
module wd_sync2 (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stage1 <= 1'b0;
            q      <= 1'b0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
    parameter int CNT_W       = 8,
    parameter int WD_PRESCALE = 64
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       chip_rst,
    input  logic       en,
    input  logic       key_we,
    input  logic [7:0] key_wdata,
    output logic       ovf
);
    import wd_reset_pkg::*;

    localparam int PW = (WD_PRESCALE > 1) ? $clog2(WD_PRESCALE) : 1;
    localparam logic [PW-1:0]    PRE_LAST = PW'(WD_PRESCALE - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    logic [PW-1:0]    pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             service;

    assign service = key_we && (key_wdata == KEY_FIRE) && armed_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            ovf     <= 1'b0;
        end else if (chip_rst) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (key_we) begin
                armed_q <= (key_wdata == KEY_ARM);
            end
            if (!en || service) begin
                pre_q <= '0;
                cnt_q <= '0;
            end else if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (cnt_q == CNT_MAX) begin
                    cnt_q <= '0;
                    ovf   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R1: an overflow pulse only follows an enabled all-ones count
    a_r1_ovf_from_max: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ovf) |-> ($past(cnt_q) == CNT_MAX) && $past(en));

    // R2: a completed key sequence leaves the counter at zero
    a_r2_key_clears: assert property (@(posedge clk) disable iff (!por_n)
        (key_we && key_wdata == KEY_FIRE && armed_q) |=> (cnt_q == '0) && !ovf);

endmodule

// File: rtl/wd_cause.sv
module wd_cause #(
    parameter int RST_PULSE    = 512,
    parameter int SAMPLE_DELAY = 8192
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       bite,
    input  logic [1:0] div_sel,
    input  logic       pin_sync,
    input  logic       flag_clr,
    output logic       pd_o,
    output logic       flag_o
);
    import wd_reset_pkg::*;

    localparam int PCW = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;
    localparam int DCW = (SAMPLE_DELAY > 1) ? $clog2(SAMPLE_DELAY) : 1;
    localparam logic [PCW-1:0] PULSE_LAST = PCW'(RST_PULSE - 1);
    localparam logic [DCW-1:0] DELAY_LAST = DCW'(SAMPLE_DELAY - 1);

    cause_state_e state_q, state_d;
    logic [PCW-1:0] pcnt_q;
    logic [DCW-1:0] dcnt_q;
    logic [1:0]     div_q;
    logic           tick;
    logic           sampling;

    assign tick = (div_q == div_last(div_sel));

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (bite) state_d = ST_PULSE;
            ST_PULSE:  if (pcnt_q == PULSE_LAST) state_d = ST_DELAY;
            ST_DELAY: begin
                if (bite)                              state_d = ST_PULSE;
                else if (tick && dcnt_q == DELAY_LAST) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pd_o     = (state_q == ST_PULSE);
        sampling = (state_q == ST_SAMPLE);
    end

    // Pulse length, system tick divider and delay counters
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pcnt_q <= '0;
            dcnt_q <= '0;
            div_q  <= '0;
        end else begin
            pcnt_q <= (state_q == ST_PULSE) ? pcnt_q + 1'b1 : '0;
            if (state_q != ST_DELAY) begin
                dcnt_q <= '0;
                div_q  <= '0;
            end else if (tick) begin
                dcnt_q <= dcnt_q + 1'b1;
                div_q  <= '0;
            end else begin
                div_q  <= div_q + 1'b1;
            end
        end
    end

    // Sticky cause flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        flag_o <= 1'b0;
        else if (!pin_sync) flag_o <= 1'b0;
        else if (sampling)  flag_o <= 1'b1;
        else if (flag_clr)  flag_o <= 1'b0;
    end

    // Independent pulse-length tally for the checker
    int unsigned ck_len;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)    ck_len <= 0;
        else if (pd_o) ck_len <= ck_len + 1;
        else           ck_len <= 0;
    end

    a_r4_pulse_len: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pd_o) |-> (ck_len == RST_PULSE));

    a_r5_low_pin_clears: assert property (@(posedge clk) disable iff (!por_n)
        !pin_sync |=> !flag_o);

    a_r6_set_at_sample: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag_o) |-> ($past(state_q) == ST_SAMPLE) && $past(pin_sync));

    a_r7_held_low_no_flag: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_SAMPLE && !pin_sync) |=> !flag_o);

endmodule

// File: rtl/wd_reset_cause.sv
module wd_reset_cause #(
    parameter int CNT_W        = 8,
    parameter int WD_PRESCALE  = 64,
    parameter int RST_PULSE    = 512,
    parameter int SAMPLE_DELAY = 8192
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic [1:0] sys_div_sel,
    input  logic       rst_pin_i,
    output logic       rst_pin_pd_o,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       key_we,
    input  logic [7:0] key_wdata,
    output logic [7:0] ctrl_rdata
);
    import wd_reset_pkg::*;

    logic pin_sync;
    logic chip_rst;
    logic en_q;
    logic bad_q;
    logic ovf;
    logic bite;
    logic flag;
    logic wr_ok;
    logic flag_clr;

    wd_sync2 u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     (rst_pin_i),
        .q     (pin_sync)
    );

    assign chip_rst = !pin_sync;
    assign wr_ok    = ctrl_we && (ctrl_wdata[5:0] == CTRL_CHECK);
    assign flag_clr = wr_ok && ctrl_wdata[7];
    assign bite     = ovf || bad_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_q  <= 1'b0;
            bad_q <= 1'b0;
        end else if (chip_rst) begin
            en_q  <= 1'b0;
            bad_q <= 1'b0;
        end else begin
            bad_q <= ctrl_we && !wr_ok;
            if (wr_ok) en_q <= ctrl_wdata[6];
        end
    end

    wd_counter #(
        .CNT_W       (CNT_W),
        .WD_PRESCALE (WD_PRESCALE)
    ) u_counter (
        .clk       (clk),
        .por_n     (por_n),
        .chip_rst  (chip_rst),
        .en        (en_q),
        .key_we    (key_we),
        .key_wdata (key_wdata),
        .ovf       (ovf)
    );

    wd_cause #(
        .RST_PULSE    (RST_PULSE),
        .SAMPLE_DELAY (SAMPLE_DELAY)
    ) u_cause (
        .clk      (clk),
        .por_n    (por_n),
        .bite     (bite),
        .div_sel  (sys_div_sel),
        .pin_sync (pin_sync),
        .flag_clr (flag_clr),
        .pd_o     (rst_pin_pd_o),
        .flag_o   (flag)
    );

    assign ctrl_rdata = {flag, en_q, 6'b000000};

    a_r3_bad_check_bites: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_we && ctrl_wdata[5:0] != CTRL_CHECK && pin_sync) |=> bite);

    a_r10_pin_low_disables: assert property (@(posedge clk) disable iff (!por_n)
        !pin_sync |=> !en_q);

endmodule

// File: tb/wd_reset_cause_tb.sv
module wd_reset_cause_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 4;
    localparam int PULSE      = 512;
    localparam int DLY        = 8192;
    localparam int WIN        = DLY * 4 + 200;

    typedef struct {
        string tag;
        int    lat;
    } exp_t;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [1:0] sel = 2'd3;
    logic       ext_low = 1'b0;
    logic       pd;
    logic       pin;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       key_we = 1'b0;
    logic [7:0] key_wdata = 8'h00;
    logic [7:0] rdata;
    int rc_delay = 20;
    int rc_left = 0;
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int done_cnt = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Open-drain pin with a board RC modelled as a release delay
    assign pin = !pd && !ext_low && (rc_left == 0);
    always @(negedge clk) begin
        if (pd)              rc_left <= rc_delay;
        else if (rc_left > 0) rc_left <= rc_left - 1;
    end

    wd_reset_cause #(.WD_PRESCALE(PRE), .RST_PULSE(PULSE), .SAMPLE_DELAY(DLY)) u_dut (
        .clk          (clk),
        .por_n        (por_n),
        .sys_div_sel  (sel),
        .rst_pin_i    (pin),
        .rst_pin_pd_o (pd),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_wdata),
        .key_we       (key_we),
        .key_wdata    (key_wdata),
        .ctrl_rdata   (rdata)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        ctrl_we = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_key(input logic [7:0] d);
        key_we = 1'b1; key_wdata = d;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic expect_reset(input string tag, input int lat);
        exp_t it;
        it.tag = tag;
        it.lat = lat;
        q.push_back(it);
        pushed++;
    endtask

    task automatic wait_pd(input int t0, output int lat);
        while (!pd) @(negedge clk);
        lat = cyc - t0;
    endtask

    task automatic wait_mon();
        wait (done_cnt >= pushed);
        @(negedge clk);
    endtask

    // Monitor: pops the expected item on each pulse and scores it
    initial begin
        exp_t it;
        int plen;
        int k;
        forever begin
            @(negedge clk);
            if (pd) begin
                plen = 1;
                @(negedge clk);
                while (pd) begin plen++; @(negedge clk); end
                chk("R4 pulse length", plen, PULSE);
                if (q.size() == 0) begin
                    chk("R1 R3 R10 unexpected reset", 1, 0);
                end else begin
                    it = q.pop_front();
                    k = 1;
                    if (it.lat < 0) begin
                        while (!rdata[7] && k < WIN) begin @(negedge clk); k++; end
                        chk(it.tag, rdata[7] ? k : -1, -1);
                    end else begin
                        while (!rdata[7] && k < WIN) begin @(negedge clk); k++; end
                        chk(it.tag, k, it.lat);
                    end
                end
                done_cnt++;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0;
        int lat;
        repeat (3) @(negedge clk);
        chk("R11 rdata in reset", rdata, 0);
        chk("R11 pd in reset", pd, 0);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 rdata after reset", rdata, 0);

        // Bad check word while disabled, divide-by-1
        sel = 2'd3; rc_delay = 20;
        expect_reset("R6 sel3 fast pin", DLY + 2);
        wr_ctrl(8'h00); t0 = cyc;
        wait_pd(t0, lat);
        chk("R3 bad check latency", lat, 1);
        wait_mon();
        chk("R9 R10 rdata after wd reset", rdata, 8'h80);

        // Write-one-to-clear and readback layout
        wr_ctrl(8'h28);
        chk("R8 write 0 keeps flag", rdata, 8'h80);
        wr_ctrl(8'hE8);
        chk("R8 R9 w1c clears and enables", rdata, 8'h40);
        wr_ctrl(8'h28);
        chk("R9 disable readback", rdata, 8'h00);

        // Counter expiry, divide-by-4
        sel = 2'd0; rc_delay = 100;
        expect_reset("R6 sel0 fast pin", DLY * 4 + 2);
        wr_ctrl(8'h68); t0 = cyc;
        wait_pd(t0, lat);
        chk("R1 expiry latency", lat, 256 * PRE + 1);
        wait_mon();
        chk("R10 enable cleared by pin", rdata, 8'h80);

        // Proper key service restarts the count
        sel = 2'd3; rc_delay = 20;
        wr_ctrl(8'h68);
        repeat (300) @(negedge clk);
        wr_key(8'h55);
        wr_key(8'hAA); t0 = cyc;
        expect_reset("R6 sel3 after service", DLY + 2);
        wait_pd(t0, lat);
        chk("R2 service restarts count", lat, 256 * PRE + 1);
        wait_mon();

        // Broken key sequence does not service
        wr_ctrl(8'h68); t0 = cyc;
        repeat (300) @(negedge clk);
        wr_key(8'h55);
        wr_key(8'h11);
        wr_key(8'hAA);
        expect_reset("R6 sel3 after broken key", DLY + 2);
        wait_pd(t0, lat);
        chk("R2 broken sequence ignored", lat, 256 * PRE + 1);
        wait_mon();

        // Nonzero reserved bit, divide-by-2
        sel = 2'd1; rc_delay = 50;
        expect_reset("R6 sel1 fast pin", DLY * 2 + 2);
        wr_ctrl(8'h29); t0 = cyc;
        wait_pd(t0, lat);
        chk("R3 reserved bit bites", lat, 1);
        wait_mon();

        // RC finishing just before the sample point
        sel = 2'd3; rc_delay = DLY - 10;
        expect_reset("R6 slow pin just in time", DLY + 2);
        wr_ctrl(8'h00);
        wait_mon();

        // RC still low at the sample point
        rc_delay = DLY + 200;
        expect_reset("R7 pin low at sample", -1);
        wr_ctrl(8'h00);
        wait_mon();
        repeat (300) @(negedge clk);
        chk("R7 flag stays 0 after release", rdata[7], 0);

        // External low with no watchdog trigger
        rc_delay = 20;
        expect_reset("R6 sel3 setup", DLY + 2);
        wr_ctrl(8'h00);
        wait_mon();
        wr_ctrl(8'h68);
        chk("R8 R9 write 0 to bit7 keeps flag", rdata, 8'hC0);
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 flag cleared by low pin", rdata[7], 0);
        ext_low = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 enable cleared by external low", rdata, 8'h00);
        wr_ctrl(8'h28);
        repeat (DLY + 500) @(negedge clk);
        chk("R7 external low never sets flag", rdata, 8'h00);
        chk("R1 R3 no pending resets", q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule